// File: doc/BRIEF.md
# Dual Parallel Port Adapter

This block sits on a processor's register bus and provides two eight-bit general-purpose ports, A and B. Each port has a direction register and an output register behind one shared data address. A control register per port selects which of the two that address reaches, and programs a pair of handshake lines. The first handshake line is an edge-sensing input. The second is either an edge-sensing input or a driven output. Each port's pins carry the output value masked by the direction bits. A direction bit of 1 turns its pin into an output.

Every handshake edge that matches its programmed polarity latches a flag. Flags are visible in the top two bits of the control register. An enabled flag raises that port's interrupt line. Software clears both flags of a port by reading its data register. The second handshake line can also be used as an output in two ways: as a level written through the control register, or as a strobe. On port A the strobe fires on a data read, and on port B it fires on a data write. The strobe ends either after one clock or at the next active edge of the first handshake line. Bus reads are combinational. Their side effects (flag clear, strobe) take place on the clock edge that closes the read cycle. Pad tristate buffers and input synchronizers live outside the block.

Top module: `dual_port_pio`

## Requirements
- R1: After reset every register is zero: all four addresses read 0x00, both ports drive 0x00 with enable 0x00, both auxiliary lines are inputs (enable 0), and both interrupts are low.
- R2: Address 0 reaches port A data, 1 control A, 2 port B data, 3 control B; the read bus is 0x00 unless select and read are both high.
- R3: Control bit 2 = 0 steers the data address to the direction register, bit 2 = 1 to the output register; a write through one leaves the other unchanged.
- R4: With bit 2 = 1 a data read returns (out AND dir) OR (pin_in AND NOT dir); with bit 2 = 0 it returns the direction register.
- R5: Port pins drive out AND dir and the enable byte equals dir.
- R6: Control writes store bits 5..0; bit 7 (edge-line flag) and bit 6 (aux-line flag) ignore written data, and bit 6 reads 0 while bit 5 = 1 (aux line is an output).
- R7: An edge-line change to the level given by bit 1 (1 = rising, 0 = falling) sets bit 7 on the next clock; the port interrupt follows when bit 0 = 1 and stays low when bit 0 = 0.
- R8: With bit 5 = 0, an aux-line change to the level given by bit 4 (1 = rising) sets bit 6; the interrupt follows when bit 3 = 1.
- R9: A data read with bit 2 = 1 clears both flags of that port only; a direction-register read clears nothing; an edge arriving in the clearing cycle wins and leaves its flag set.
- R10: With bits 5 = 1 and 4 = 1 the aux line is enabled as an output and drives control bit 3, updated by the control write.
- R11: With bit 5 = 1 and bit 4 = 0, a port A data read (port B: data write) with bit 2 = 1 drives the aux line low; bit 3 = 1 releases it high one clock later, bit 3 = 0 keeps it low until the next active edge-line edge. The opposite access type does not strobe.
- R12: The two ports' flags and interrupts are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register bus select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| porta_in | input | 8 | Port A sampled pins |
| porta_out | output | 8 | Port A pin drive |
| porta_oe | output | 8 | Port A per-pin output enable |
| portb_in | input | 8 | Port B sampled pins |
| portb_out | output | 8 | Port B pin drive |
| portb_oe | output | 8 | Port B per-pin output enable |
| a_edge_in | input | 1 | Port A edge-sensing handshake input |
| a_aux_in | input | 1 | Port A auxiliary line, input side |
| a_aux_out | output | 1 | Port A auxiliary line, drive value |
| a_aux_oe | output | 1 | Port A auxiliary line, output enable |
| b_edge_in | input | 1 | Port B edge-sensing handshake input |
| b_aux_in | input | 1 | Port B auxiliary line, input side |
| b_aux_out | output | 1 | Port B auxiliary line, drive value |
| b_aux_oe | output | 1 | Port B auxiliary line, output enable |
| irq_a | output | 1 | Port A interrupt |
| irq_b | output | 1 | Port B interrupt |

## Verification
The read-back merge is swept on both ports over 16 direction masks crossed with 16 pin patterns. The output value changes with the mask, so a swapped AND/OR term or the wrong register behind the address shows up as a mismatched bit. The handshake lines are driven with both edge directions against both polarity settings, and with the enable bit set and clear. This separates edge matching from level sensing and flag latching from interrupt gating. Flag clearing is tried with a data read, with a direction-register read, and with an edge landing in the very clearing cycle. The strobe is driven with the triggering and the non-triggering access on each port, under both release options, so that pulse length and access type are told apart.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int REG_W = 8;
  localparam int CTL_W = 6;
  localparam int NPORT = 2;
  localparam int SEL_W = $clog2(NPORT) + 1;

  // stored control bits, msb first: bit5 .. bit0
  typedef struct packed {
    logic aux_dir;    // 1: aux line is an output
    logic aux_mode;   // input: 1 rising; output: 1 level, 0 strobe
    logic aux_opt;    // input: irq enable; level: value; strobe: fast release
    logic out_sel;    // 1: data address reaches output register
    logic edge_rise;  // 1: rising edge active on edge line
    logic edge_ie;    // edge flag interrupt enable
  } ctl_t;
endpackage

// File: rtl/pio_portregs.sv
module pio_portregs
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] pin_in,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] pin_out,
  output logic [REG_W-1:0] pin_oe
);
  logic [REG_W-1:0] dir_q;
  logic [REG_W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      if (out_sel) out_q <= wdata;
      else         dir_q <= wdata;
    end
  end

  assign pin_out = out_q & dir_q;
  assign pin_oe  = dir_q;
  assign rdata   = out_sel ? ((out_q & dir_q) | (pin_in & ~dir_q)) : dir_q;

  // R3: direction write lands in the enable byte
  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !out_sel) |=> (pin_oe == $past(wdata)));
  // R3: output write leaves direction untouched
  a_r3_out_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && out_sel) |=> $stable(pin_oe));
  // R5: no pin is driven high unless it is enabled
  a_r5_drive_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));
endmodule

// File: rtl/pio_handshake.sv
module pio_handshake
  import pio_pkg::*;
#(
  parameter bit STROBE_ON_WRITE = 1'b0
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             data_rd,
  input  logic             data_wr,
  input  logic             edge_in,
  input  logic             aux_in,
  output logic             out_sel,
  output logic [REG_W-1:0] ctl_rdata,
  output logic             aux_out,
  output logic             aux_oe,
  output logic             irq
);
  ctl_t cq;
  logic flag_e, flag_a;
  logic edge_q, aux_q;
  logic aux_drv;
  logic ev_edge, ev_aux, clr, strb_acc, strb_mode;

  assign ev_edge   = (edge_in ^ edge_q) && (edge_in == cq.edge_rise);
  assign ev_aux    = !cq.aux_dir && (aux_in ^ aux_q) && (aux_in == cq.aux_mode);
  assign clr       = data_rd && cq.out_sel;
  assign strb_acc  = (STROBE_ON_WRITE ? data_wr : data_rd) && cq.out_sel;
  assign strb_mode = cq.aux_dir && !cq.aux_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq     <= '0;
      edge_q <= 1'b0;
      aux_q  <= 1'b0;
    end else begin
      edge_q <= edge_in;
      aux_q  <= aux_in;
      if (ctl_we) cq <= ctl_t'(ctl_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_e <= 1'b0;
      flag_a <= 1'b0;
    end else begin
      if (ev_edge)  flag_e <= 1'b1;
      else if (clr) flag_e <= 1'b0;
      if (ev_aux)   flag_a <= 1'b1;
      else if (clr) flag_a <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_drv <= 1'b0;
    end else if (ctl_we && ctl_wdata[5] && ctl_wdata[4]) begin
      aux_drv <= ctl_wdata[3];
    end else if (strb_mode && strb_acc) begin
      aux_drv <= 1'b0;
    end else if (strb_mode && !aux_drv && (cq.aux_opt || ev_edge)) begin
      aux_drv <= 1'b1;
    end
  end

  assign out_sel   = cq.out_sel;
  assign aux_out   = aux_drv;
  assign aux_oe    = cq.aux_dir;
  assign ctl_rdata = {flag_e, flag_a & !cq.aux_dir, cq};
  assign irq       = (flag_e && cq.edge_ie) || (flag_a && !cq.aux_dir && cq.aux_opt);

  // R7: an active edge always latches its flag
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_edge |=> flag_e);
  // R8: an active aux edge latches its flag
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_aux |=> flag_a);
  // R9: a clearing read with no new edge empties the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_edge) |=> !flag_e);
  // R6: the control write stores the low six bits
  a_r6_ctl_store: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (CTL_W'(cq) == $past(ctl_wdata)));
  // R11: a triggering access pulls the strobe low
  a_r11_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_mode && strb_acc && !ctl_we) |=> !aux_out);
endmodule

// File: rtl/dual_port_pio.sv
module dual_port_pio
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cs,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [REG_W-1:0] porta_in,
  output logic [REG_W-1:0] porta_out,
  output logic [REG_W-1:0] porta_oe,
  input  logic [REG_W-1:0] portb_in,
  output logic [REG_W-1:0] portb_out,
  output logic [REG_W-1:0] portb_oe,
  input  logic             a_edge_in,
  input  logic             a_aux_in,
  output logic             a_aux_out,
  output logic             a_aux_oe,
  input  logic             b_edge_in,
  input  logic             b_aux_in,
  output logic             b_aux_out,
  output logic             b_aux_oe,
  output logic             irq_a,
  output logic             irq_b
);
  logic [REG_W-1:0] pin_in  [NPORT];
  logic [REG_W-1:0] pin_out [NPORT];
  logic [REG_W-1:0] pin_oe  [NPORT];
  logic [REG_W-1:0] dat_rd  [NPORT];
  logic [REG_W-1:0] ctl_rd  [NPORT];
  logic [NPORT-1:0] edge_v, aux_in_v, aux_out_v, aux_oe_v, irq_v;

  assign pin_in[0] = porta_in;
  assign pin_in[1] = portb_in;
  assign edge_v    = {b_edge_in, a_edge_in};
  assign aux_in_v  = {b_aux_in, a_aux_in};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit, data_hit, ctl_hit, sel_q;
    assign hit      = bus_cs && (bus_sel[SEL_W-1:1] == (SEL_W-1)'(p));
    assign data_hit = hit && !bus_sel[0];
    assign ctl_hit  = hit && bus_sel[0];

    pio_handshake #(.STROBE_ON_WRITE(p == 1)) u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_hit && bus_wr),
      .ctl_wdata (bus_wdata[CTL_W-1:0]),
      .data_rd   (data_hit && bus_rd),
      .data_wr   (data_hit && bus_wr),
      .edge_in   (edge_v[p]),
      .aux_in    (aux_in_v[p]),
      .out_sel   (sel_q),
      .ctl_rdata (ctl_rd[p]),
      .aux_out   (aux_out_v[p]),
      .aux_oe    (aux_oe_v[p]),
      .irq       (irq_v[p])
    );

    pio_portregs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .out_sel (sel_q),
      .wr_en   (data_hit && bus_wr),
      .wdata   (bus_wdata),
      .pin_in  (pin_in[p]),
      .rdata   (dat_rd[p]),
      .pin_out (pin_out[p]),
      .pin_oe  (pin_oe[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_cs && bus_rd)
      bus_rdata = bus_sel[0] ? ctl_rd[bus_sel[SEL_W-1:1]] : dat_rd[bus_sel[SEL_W-1:1]];
  end

  assign porta_out = pin_out[0];
  assign porta_oe  = pin_oe[0];
  assign portb_out = pin_out[1];
  assign portb_oe  = pin_oe[1];
  assign a_aux_out = aux_out_v[0];
  assign a_aux_oe  = aux_oe_v[0];
  assign b_aux_out = aux_out_v[1];
  assign b_aux_oe  = aux_oe_v[1];
  assign irq_a     = irq_v[0];
  assign irq_b     = irq_v[1];

  // R2: an idle bus returns zero
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && bus_rd) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_dual_port_pio.sv
`timescale 1ns/1ps
module sim_dual_port_pio;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0;
  logic [1:0] sel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [7:0] pa_i = 0, pb_i = 0;
  logic [7:0] pa_o, pa_e, pb_o, pb_e;
  logic ae = 0, aa = 0, be = 0, ba = 0;
  logic aa_o, aa_e, ba_o, ba_e, ia, ib;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  dual_port_pio u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_rd(rd), .bus_wr(wr),
    .bus_sel(sel), .bus_wdata(wdata), .bus_rdata(rdata),
    .porta_in(pa_i), .porta_out(pa_o), .porta_oe(pa_e),
    .portb_in(pb_i), .portb_out(pb_o), .portb_oe(pb_e),
    .a_edge_in(ae), .a_aux_in(aa), .a_aux_out(aa_o), .a_aux_oe(aa_e),
    .b_edge_in(be), .b_aux_in(ba), .b_aux_out(ba_o), .b_aux_oe(ba_e),
    .irq_a(ia), .irq_b(ib));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; sel = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] q);
    @(negedge clk); cs = 1; rd = 1; sel = a;
    #1 q = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got 00 expected 01");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) tick();
    rst_n = 1;
    pa_i = 8'hFF; pb_i = 8'hFF;
    tick();
    // R1 reset state
    check("R1 irq", {6'd0, ib, ia}, 8'h00);
    check("R1 pins", pa_o | pa_e | pb_o | pb_e, 8'h00);
    check("R1 aux oe", {6'd0, ba_e, aa_e}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      do_rd(2'(a), q);
      check("R1 read", q, 8'h00);
    end
    check("R2 idle bus", rdata, 8'h00);
    // R2 / R3 address map and steering
    do_wr(2'd0, 8'h0F);
    do_wr(2'd2, 8'hF0);
    check("R3 dir A", pa_e, 8'h0F);
    check("R2 dir B", pb_e, 8'hF0);
    do_rd(2'd0, q); check("R3 dir readback", q, 8'h0F);
    do_wr(2'd1, 8'h04);
    do_wr(2'd3, 8'h04);
    do_wr(2'd0, 8'hAA);
    check("R3 out keeps dir", pa_e, 8'h0F);
    check("R5 out A", pa_o, 8'h0A);
    do_rd(2'd1, q); check("R2 ctl A", q, 8'h04);
    do_rd(2'd3, q); check("R2 ctl B", q, 8'h04);
    // R4 / R5 sweep on both ports
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 16; i++) begin
        logic [7:0] d, o;
        d = 8'(i * 37 + 5);
        o = 8'(i * 91 + 3);
        do_wr({1'(p), 1'b1}, 8'h00);
        do_wr({1'(p), 1'b0}, d);
        do_wr({1'(p), 1'b1}, 8'h04);
        do_wr({1'(p), 1'b0}, o);
        check("R5 drive", p == 0 ? pa_o : pb_o, o & d);
        check("R5 enable", p == 0 ? pa_e : pb_e, d);
        for (int j = 0; j < 16; j++) begin
          logic [7:0] pin;
          pin = 8'(j * 53 + 11);
          if (p == 0) pa_i = pin; else pb_i = pin;
          do_rd({1'(p), 1'b0}, q);
          check("R4 merge", q, (o & d) | (pin & ~d));
        end
      end
    end
    // R6 status bits read-only
    do_wr(2'd1, 8'hC4);
    do_rd(2'd1, q); check("R6 flags ignore write", q, 8'h04);
    // R7 edge flag and interrupt
    do_wr(2'd1, 8'h07);
    ae = 1; tick();
    check("R7 irq a", {7'd0, ia}, 8'h01);
    check("R12 irq b quiet", {7'd0, ib}, 8'h00);
    do_rd(2'd3, q); check("R12 ctl B flags", q, 8'h04);
    do_rd(2'd1, q); check("R7 flag", q, 8'h87);
    do_rd(2'd0, q);
    check("R9 irq cleared", {7'd0, ia}, 8'h00);
    do_rd(2'd1, q); check("R9 flags cleared", q, 8'h07);
    ae = 0; tick(); tick();
    check("R7 wrong polarity", {7'd0, ia}, 8'h00);
    do_rd(2'd1, q); check("R7 wrong polarity flag", q, 8'h07);
    do_wr(2'd1, 8'h06);
    ae = 1; tick();
    check("R7 masked irq", {7'd0, ia}, 8'h00);
    do_rd(2'd1, q); check("R7 masked flag", q, 8'h86);
    do_wr(2'd1, 8'h02);
    do_rd(2'd0, q);
    do_rd(2'd1, q); check("R9 dir read keeps flag", q, 8'h82);
    do_wr(2'd1, 8'h06);
    do_rd(2'd0, q);
    do_rd(2'd1, q); check("R9 data read clears", q, 8'h06);
    // R8 aux input edges on port B
    do_wr(2'd3, 8'h1C);
    ba = 1; tick();
    check("R8 irq b", {7'd0, ib}, 8'h01);
    check("R12 irq a quiet", {7'd0, ia}, 8'h00);
    do_rd(2'd3, q); check("R8 flag", q, 8'h5C);
    do_rd(2'd2, q);
    do_rd(2'd3, q); check("R9 clear B", q, 8'h1C);
    do_wr(2'd3, 8'h0C);
    ba = 0; tick();
    do_rd(2'd3, q); check("R8 falling flag", q, 8'h4C);
    check("R8 irq falling", {7'd0, ib}, 8'h01);
    // R9 edge in the clearing cycle wins
    ae = 0; do_wr(2'd1, 8'h07); tick();
    @(negedge clk); cs = 1; rd = 1; sel = 2'd0; ae = 1;
    @(negedge clk); cs = 0; rd = 0;
    check("R9 edge wins irq", {7'd0, ia}, 8'h01);
    do_rd(2'd1, q); check("R9 edge wins flag", q, 8'h87);
    do_rd(2'd0, q);
    // R6 aux flag masked when output
    do_wr(2'd1, 8'h1C);
    aa = 1; tick();
    do_rd(2'd1, q); check("R8 aux A flag", q, 8'h5C);
    do_wr(2'd1, 8'h3C);
    do_rd(2'd1, q); check("R6 aux flag masked", q, 8'h3C);
    check("R6 irq masked", {7'd0, ia}, 8'h00);
    // R10 level mode
    check("R10 level high", {6'd0, aa_e, aa_o}, 8'h03);
    do_wr(2'd1, 8'h34);
    check("R10 level low", {6'd0, aa_e, aa_o}, 8'h02);
    do_wr(2'd1, 8'h3C);
    // R11 fast strobe on A read
    do_wr(2'd1, 8'h2C);
    check("R11 enter keeps", {7'd0, aa_o}, 8'h01);
    do_rd(2'd0, q);
    check("R11 fast low", {7'd0, aa_o}, 8'h00);
    tick();
    check("R11 fast release", {7'd0, aa_o}, 8'h01);
    do_wr(2'd0, 8'h55);
    check("R11 A write no strobe", {7'd0, aa_o}, 8'h01);
    // R11 slow strobe on A, released by falling edge line
    do_wr(2'd1, 8'h24);
    do_rd(2'd0, q);
    tick(); tick(); tick();
    check("R11 slow held", {7'd0, aa_o}, 8'h00);
    ae = 0; tick();
    check("R11 slow release", {7'd0, aa_o}, 8'h01);
    // R11 port B strobes on write
    do_wr(2'd3, 8'h3C);
    do_wr(2'd3, 8'h2C);
    do_rd(2'd2, q);
    check("R11 B read no strobe", {7'd0, ba_o}, 8'h01);
    do_wr(2'd2, 8'h33);
    check("R11 B write low", {7'd0, ba_o}, 8'h00);
    tick();
    check("R11 B release", {7'd0, ba_o}, 8'h01);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule